// File: doc/BRIEF.md
# Coprocessor High-Half Register Move Unit

This block carries out the two system-control instructions that move the upper 32 bits of wide control registers to and from a general register. It serves a core whose datapath is 32 bits wide. It decodes the instruction word and gates each move by two feature enables. It holds four 64-bit registers: two translation entry-low registers, a load-linked address register and a cache tag-low register. It returns read data with a general-register write strobe, and it flags a reserved-instruction exception when the move-high capability is absent.

The rest of the core loads whole 64-bit values into the registers through a separate full-width load port. This port carries the low-half moves and the load-linked address updates. The current contents are driven out continuously to the translation and cache logic. Read data is combinational in the cycle the instruction is presented. A high-half write takes effect at the next clock edge.

Top module: `hh_move_unit`

## Requirements
- R1: An instruction is acted on only when `instr_valid` is high and `instr[31:26]` is 6'h10. Field `instr[25:21]` equal to 5'h02 is a read-high and 5'h06 is a write-high. Any other value of that field gives `rd_we`=0 and `ri_exc`=0, and no register changes.
- R2: When `cap_move_hi` is 0, a read-high or a write-high raises `ri_exc`. In that cycle `rd_we` is 0 and no register changes.
- R3: When `ext_pa_en` is 0 and `cap_move_hi` is 1, a read-high returns zero with `rd_we`=1, and a write-high leaves every register unchanged.
- R4: The target register number is `instr[15:11]` and the select is `instr[2:0]`. Register 2 select 0 is entry-low 0 and register 3 select 0 is entry-low 1. Any other register or select reads zero and ignores writes.
- R5: With `WIDE64`=1 the entry-low high half is bits [61:30]. With `WIDE64`=0 it is bits [63:32].
- R6: A write-high to an entry-low or tag-low register stores `gpr_val` ANDed with the physical-address mask shifted right by 36. The mask is 0xF for `PABITS`=40. All bits outside the high half keep their values.
- R7: A read-high of register 17 select 0 returns the load-linked register shifted right by 32+`LL_SHIFT` (36 by default). A write-high to that register is ignored.
- R8: Register 28 is the tag-low register at selects 0, 2, 4 and 6, and its high half is bits [63:32]. Odd selects of register 28 read zero and ignore writes.
- R9: A read-high whose `instr[20:16]` is 0 gives `rd_we`=0 and `rd_data`=0. `rd_data` is zero whenever `rd_we` is 0.
- R10: While `rst_n` is low, all four registers are zero.
- R11: `ld_en` writes `ld_data` to the register chosen by `ld_idx` at the next edge. The encoding is 0 entry-low 0, 1 entry-low 1, 2 load-linked, 3 tag-low. An accepted write-high to the same register in the same cycle takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| gpr_val | input | 32 | Source general-register value for write-high |
| cap_move_hi | input | 1 | Move-high capability present |
| ext_pa_en | input | 1 | Extended physical addressing enabled |
| ld_en | input | 1 | Full-width register load strobe |
| ld_idx | input | 2 | Register chosen for the full-width load |
| ld_data | input | 64 | Full-width load value |
| rd_data | output | 32 | Read-high result |
| rd_we | output | 1 | Write `rd_data` to the destination general register |
| ri_exc | output | 1 | Reserved-instruction exception |
| elo0_q | output | 64 | Entry-low 0 contents |
| elo1_q | output | 64 | Entry-low 1 contents |
| lla_q | output | 64 | Load-linked address contents |
| tag_q | output | 64 | Tag-low contents |

## Verification
The bench goes after the 30-bit split of the entry-low registers. A design that used 32 there would return values off by a factor of four and would clobber bits 62 and 63. It also checks that both enables gate independently. Confusing them would either throw exceptions when extended addressing is off or write zero into the register file when the capability is missing. Odd tag-low selects, writes to the load-linked register, a destination of zero and a load colliding with a write-high are all probed. Each of these would show up as a corrupted neighbour, a spurious strobe or a lost update.

// File: rtl/hh_move_pkg.sv
package hh_move_pkg;
  localparam logic [5:0] OPC_SYSCTL = 6'h10;
  localparam logic [4:0] FN_READ_HI = 5'h02;
  localparam logic [4:0] FN_WRITE_HI = 5'h06;
  localparam logic [4:0] NUM_ELO0 = 5'd2;
  localparam logic [4:0] NUM_ELO1 = 5'd3;
  localparam logic [4:0] NUM_LLA = 5'd17;
  localparam logic [4:0] NUM_TAG = 5'd28;
  localparam int NSLOTS = 4;

  typedef enum logic [1:0] {
    SLOT_ELO0 = 2'd0,
    SLOT_ELO1 = 2'd1,
    SLOT_LLA  = 2'd2,
    SLOT_TAG  = 2'd3
  } slot_e;

  typedef struct packed {
    logic  is_rd;
    logic  is_wr;
    logic  dst_zero;
    logic  hit;
    slot_e slot;
  } dec_t;
endpackage

// File: rtl/hh_rst_sync.sv
module hh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/hh_decode.sv
module hh_decode
  import hh_move_pkg::*;
(
  input  logic        instr_valid,
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic       grp_ok;
  logic [4:0] fn_f, dst_f, num_f;
  logic [2:0] sel_f;
  logic       unused_mid;

  assign grp_ok = instr_valid && (instr[31:26] == OPC_SYSCTL);
  assign fn_f   = instr[25:21];
  assign dst_f  = instr[20:16];
  assign num_f  = instr[15:11];
  assign sel_f  = instr[2:0];
  assign unused_mid = ^instr[10:3];

  always_comb begin
    dec          = '0;
    dec.is_rd    = grp_ok && (fn_f == FN_READ_HI);
    dec.is_wr    = grp_ok && (fn_f == FN_WRITE_HI);
    dec.dst_zero = (dst_f == 5'd0);
    dec.hit      = 1'b0;
    dec.slot     = SLOT_ELO0;
    unique case (num_f)
      NUM_ELO0: begin dec.hit = (sel_f == 3'd0); dec.slot = SLOT_ELO0; end
      NUM_ELO1: begin dec.hit = (sel_f == 3'd0); dec.slot = SLOT_ELO1; end
      NUM_LLA:  begin dec.hit = (sel_f == 3'd0); dec.slot = SLOT_LLA;  end
      NUM_TAG:  begin dec.hit = ~sel_f[0];       dec.slot = SLOT_TAG;  end
      default:  begin dec.hit = 1'b0;            dec.slot = SLOT_ELO0; end
    endcase
  end
endmodule

// File: rtl/hh_slot.sv
module hh_slot #(
  parameter int          REG_W   = 64,
  parameter int          SPLIT   = 32,
  parameter logic [31:0] HI_MASK = 32'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_we,
  input  logic [31:0]      hi_data,
  input  logic             ld_en,
  input  logic [REG_W-1:0] ld_data,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] nxt;
  logic [31:0]      masked;
  logic             en;

  assign masked = hi_data & HI_MASK;
  assign en     = hi_we | ld_en;

  always_comb begin
    nxt = q;
    if (hi_we) begin
      for (int i = 0; i < 32; i++) begin
        if (SPLIT + i < REG_W) nxt[SPLIT+i] = masked[i];
      end
    end else if (ld_en) begin
      nxt = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/hh_read_sel.sv
module hh_read_sel
  import hh_move_pkg::*;
#(
  parameter int REG_W     = 64,
  parameter int ELO_SPLIT = 30,
  parameter int LL_SHIFT  = 4
) (
  input  dec_t             dec,
  input  logic             cap_ok,
  input  logic             pa_ok,
  input  logic [REG_W-1:0] elo0,
  input  logic [REG_W-1:0] elo1,
  input  logic [REG_W-1:0] lla,
  input  logic [REG_W-1:0] tag,
  output logic [31:0]      rd_data,
  output logic             rd_we
);
  localparam int LL_POS = 32 + LL_SHIFT;
  logic [31:0] hi_val;

  always_comb begin
    hi_val = '0;
    if (pa_ok && dec.hit) begin
      unique case (dec.slot)
        SLOT_ELO0: hi_val = 32'(elo0 >> ELO_SPLIT);
        SLOT_ELO1: hi_val = 32'(elo1 >> ELO_SPLIT);
        SLOT_LLA:  hi_val = 32'(lla >> LL_POS);
        SLOT_TAG:  hi_val = 32'(tag >> 32);
        default:   hi_val = '0;
      endcase
    end
  end

  assign rd_we   = dec.is_rd && cap_ok && !dec.dst_zero;
  assign rd_data = rd_we ? hi_val : 32'd0;
endmodule

// File: rtl/hh_move_unit.sv
module hh_move_unit
  import hh_move_pkg::*;
#(
  parameter bit WIDE64   = 1'b1,
  parameter int PABITS   = 40,
  parameter int LL_SHIFT = 4,
  parameter int REG_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [31:0]      instr,
  input  logic [31:0]      gpr_val,
  input  logic             cap_move_hi,
  input  logic             ext_pa_en,
  input  logic             ld_en,
  input  logic [1:0]       ld_idx,
  input  logic [REG_W-1:0] ld_data,
  output logic [31:0]      rd_data,
  output logic             rd_we,
  output logic             ri_exc,
  output logic [REG_W-1:0] elo0_q,
  output logic [REG_W-1:0] elo1_q,
  output logic [REG_W-1:0] lla_q,
  output logic [REG_W-1:0] tag_q
);
  localparam int          ELO_SPLIT = WIDE64 ? 30 : 32;
  localparam logic [63:0] PA_MASK   = (64'd1 << PABITS) - 64'd1;
  localparam logic [31:0] HI_MASK   = 32'(PA_MASK >> 36);

  logic             rst_n_int;
  dec_t             dec;
  logic             wr_ok;
  logic [REG_W-1:0] q_arr [NSLOTS];

  hh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hh_decode u_dec (
    .instr_valid (instr_valid),
    .instr       (instr),
    .dec         (dec)
  );

  assign ri_exc = (dec.is_rd || dec.is_wr) && !cap_move_hi;
  assign wr_ok  = dec.is_wr && cap_move_hi && ext_pa_en && dec.hit &&
                  (dec.slot != SLOT_LLA);

  for (genvar k = 0; k < NSLOTS; k++) begin : g_slot
    localparam int SPL = (k < 2) ? ELO_SPLIT : 32;
    logic hi_we_k, ld_en_k;
    assign hi_we_k = wr_ok && (dec.slot == slot_e'(k));
    assign ld_en_k = ld_en && (ld_idx == 2'(k));
    hh_slot #(
      .REG_W   (REG_W),
      .SPLIT   (SPL),
      .HI_MASK (HI_MASK)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .hi_we   (hi_we_k),
      .hi_data (gpr_val),
      .ld_en   (ld_en_k),
      .ld_data (ld_data),
      .q       (q_arr[k])
    );
  end

  assign elo0_q = q_arr[0];
  assign elo1_q = q_arr[1];
  assign lla_q  = q_arr[2];
  assign tag_q  = q_arr[3];

  hh_read_sel #(
    .REG_W     (REG_W),
    .ELO_SPLIT (ELO_SPLIT),
    .LL_SHIFT  (LL_SHIFT)
  ) u_rd (
    .dec     (dec),
    .cap_ok  (cap_move_hi),
    .pa_ok   (ext_pa_en),
    .elo0    (q_arr[0]),
    .elo1    (q_arr[1]),
    .lla     (q_arr[2]),
    .tag     (q_arr[3]),
    .rd_data (rd_data),
    .rd_we   (rd_we)
  );
endmodule

// File: rtl/hh_move_unit_chk.sv
module hh_move_unit_chk #(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic [31:0]      instr,
  input logic             ext_pa_en,
  input logic             ld_en,
  input logic [31:0]      rd_data,
  input logic             rd_we,
  input logic             ri_exc,
  input logic [REG_W-1:0] elo0_q,
  input logic [REG_W-1:0] elo1_q,
  input logic [REG_W-1:0] lla_q,
  input logic [REG_W-1:0] tag_q
);
  logic       grp, is_r, is_w;
  logic [4:0] fn;
  logic       chk_unused;

  assign chk_unused = ^instr[10:3];
  assign fn   = instr[25:21];
  assign grp  = instr_valid && (instr[31:26] == 6'h10);
  assign is_r = grp && (fn == 5'h02);
  assign is_w = grp && (fn == 5'h06);

  assert_other_fn_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && !is_r && !is_w) |-> (!rd_we && !ri_exc));

  assert_exc_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ri_exc |-> !rd_we);

  assert_exc_no_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_exc && !ld_en) |=> ($stable(elo0_q) && $stable(elo1_q) &&
                            $stable(lla_q) && $stable(tag_q)));

  assert_pa_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we && !ext_pa_en) |-> (rd_data == 32'd0));

  assert_pa_off_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_w && !ext_pa_en && !ld_en) |=> ($stable(elo0_q) && $stable(elo1_q) &&
                                        $stable(tag_q)));

  assert_low_bits_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_w && !ld_en) |=> ($stable(elo0_q[29:0]) && $stable(elo1_q[29:0]) &&
                          $stable(tag_q[31:0])));

  assert_ll_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_w && !ld_en) |=> $stable(lla_q));

  assert_zero_dst_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_r && instr[20:16] == 5'd0) |-> (!rd_we && rd_data == 32'd0));
endmodule

bind hh_move_unit hh_move_unit_chk #(.REG_W(REG_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .ext_pa_en   (ext_pa_en),
  .ld_en       (ld_en),
  .rd_data     (rd_data),
  .rd_we       (rd_we),
  .ri_exc      (ri_exc),
  .elo0_q      (elo0_q),
  .elo1_q      (elo1_q),
  .lla_q       (lla_q),
  .tag_q       (tag_q)
);

// File: tb/hh_move_unit_tb_top.sv
`timescale 1ns/1ps
module hh_move_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic [31:0] gpr_val;
  logic        cap_move_hi, ext_pa_en;
  logic        ld_en;
  logic [1:0]  ld_idx;
  logic [63:0] ld_data;
  logic [31:0] rd_data;
  logic        rd_we, ri_exc;
  logic [63:0] elo0_q, elo1_q, lla_q, tag_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hh_move_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .gpr_val(gpr_val), .cap_move_hi(cap_move_hi), .ext_pa_en(ext_pa_en),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_data(rd_data), .rd_we(rd_we), .ri_exc(ri_exc),
    .elo0_q(elo0_q), .elo1_q(elo1_q), .lla_q(lla_q), .tag_q(tag_q)
  );

  typedef struct packed {
    logic [4:0]  fn;
    logic [4:0]  dst;
    logic [4:0]  num;
    logic [2:0]  sel;
    logic [31:0] wd;
    logic        cap;
    logic        pa;
    logic        e_we;
    logic        e_exc;
    logic [31:0] e_data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{5'h02, 5'd5, 5'd2,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h048D159E, 4'd5},  // R5
    '{5'h02, 5'd5, 5'd3,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'hFB72EA61, 4'd5},  // R5
    '{5'h02, 5'd5, 5'd17, 3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0A5A5123, 4'd7},  // R7
    '{5'h02, 5'd5, 5'd28, 3'd2, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h11112222, 4'd8},  // R8
    '{5'h02, 5'd5, 5'd28, 3'd1, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        4'd8},  // R8
    '{5'h02, 5'd5, 5'd2,  3'd1, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        4'd4},  // R4
    '{5'h02, 5'd5, 5'd5,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        4'd4},  // R4
    '{5'h06, 5'd5, 5'd2,  3'd0, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd6},  // R6
    '{5'h02, 5'd5, 5'd2,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0000000F, 4'd6},  // R6
    '{5'h06, 5'd5, 5'd28, 3'd4, 32'h12345678, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd8},  // R8
    '{5'h02, 5'd5, 5'd28, 3'd6, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000008, 4'd8},  // R8
    '{5'h06, 5'd5, 5'd17, 3'd0, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd7},  // R7
    '{5'h02, 5'd5, 5'd17, 3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0A5A5123, 4'd7},  // R7
    '{5'h06, 5'd5, 5'd28, 3'd3, 32'h0000000F, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd8},  // R8
    '{5'h02, 5'd5, 5'd28, 3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000008, 4'd8},  // R8
    '{5'h02, 5'd5, 5'd3,  3'd0, 32'h0,        1'b1, 1'b0, 1'b1, 1'b0, 32'h0,        4'd3},  // R3
    '{5'h06, 5'd5, 5'd3,  3'd0, 32'h00000005, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        4'd3},  // R3
    '{5'h02, 5'd5, 5'd3,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'hFB72EA61, 4'd3},  // R3
    '{5'h02, 5'd5, 5'd3,  3'd0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'h0,        4'd2},  // R2
    '{5'h06, 5'd5, 5'd3,  3'd0, 32'h00000003, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0,        4'd2},  // R2
    '{5'h02, 5'd5, 5'd3,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'hFB72EA61, 4'd2},  // R2
    '{5'h02, 5'd0, 5'd2,  3'd0, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd9},  // R9
    '{5'h04, 5'd5, 5'd2,  3'd0, 32'h00000007, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd1},  // R1
    '{5'h02, 5'd5, 5'd2,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h0000000F, 4'd1},  // R1
    '{5'h06, 5'd5, 5'd3,  3'd0, 32'h00000006, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,        4'd6},  // R6
    '{5'h02, 5'd5, 5'd3,  3'd0, 32'h0,        1'b1, 1'b1, 1'b1, 1'b0, 32'h00000006, 4'd6},  // R6
    '{5'h02, 5'd0, 5'd3,  3'd0, 32'h0,        1'b0, 1'b1, 1'b0, 1'b1, 32'h0,        4'd2}   // R2
  };

  function automatic logic [31:0] mk_instr(logic [4:0] fn, logic [4:0] dst,
                                           logic [4:0] num, logic [2:0] sel);
    return {6'h10, fn, dst, num, 8'h00, sel};
  endfunction

  task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    instr_valid = 1'b0; instr = '0; gpr_val = '0;
    cap_move_hi = 1'b1; ext_pa_en = 1'b1;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0;
  endtask

  task automatic load(logic [1:0] idx, logic [63:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = val;
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_vec(vec_t v);
    logic [33:0] act, exp;
    @(negedge clk);
    instr_valid = 1'b1;
    instr       = mk_instr(v.fn, v.dst, v.num, v.sel);
    gpr_val     = v.wd;
    cap_move_hi = v.cap;
    ext_pa_en   = v.pa;
    #2;
    act = {rd_we, ri_exc, rd_data};
    exp = {v.e_we, v.e_exc, v.e_data};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d we/exc/data actual %h expected %h", v.req, act, exp);
    end
    @(posedge clk);
    #1;
    instr_valid = 1'b0; cap_move_hi = 1'b1; ext_pa_en = 1'b1;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: registers are zero while reset is held
    chk64("R10 elo0", elo0_q, 64'h0);
    chk64("R10 elo1", elo1_q, 64'h0);
    chk64("R10 lla",  lla_q,  64'h0);
    chk64("R10 tag",  tag_q,  64'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: full-width loads
    load(2'd0, 64'h0123_4567_89AB_CDEF);
    load(2'd1, 64'hFEDC_BA98_7654_3210);
    load(2'd2, 64'hA5A5_1234_5678_9ABC);
    load(2'd3, 64'h1111_2222_3333_4444);
    chk64("R11 lla load", lla_q, 64'hA5A5_1234_5678_9ABC);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    @(negedge clk);
    // R6: only the high field changed, bits outside it kept
    chk64("R6 elo0 full", elo0_q, 64'h0000_0003_C9AB_CDEF);
    chk64("R6 elo1 full", elo1_q, 64'hC000_0001_B654_3210);
    chk64("R8 tag full",  tag_q,  64'h0000_0008_3333_4444);
    chk64("R7 lla full",  lla_q,  64'hA5A5_1234_5678_9ABC);

    // R11: write-high beats a colliding load of the same register
    @(negedge clk);
    instr_valid = 1'b1;
    instr       = mk_instr(5'h06, 5'd5, 5'd2, 3'd0);
    gpr_val     = 32'h0000_0001;
    ld_en = 1'b1; ld_idx = 2'd0; ld_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(posedge clk);
    #1;
    idle();
    @(negedge clk);
    chk64("R11 collision", elo0_q, 64'h0000_0000_49AB_CDEF);

    // R11: a load to another register proceeds beside a write-high
    @(negedge clk);
    instr_valid = 1'b1;
    instr       = mk_instr(5'h06, 5'd5, 5'd2, 3'd0);
    gpr_val     = 32'h0000_0002;
    ld_en = 1'b1; ld_idx = 2'd3; ld_data = 64'hDEAD_BEEF_0000_1234;
    @(posedge clk);
    #1;
    idle();
    @(negedge clk);
    chk64("R11 side load tag", tag_q, 64'hDEAD_BEEF_0000_1234);
    chk64("R11 side write elo0", elo0_q, 64'h0000_0000_89AB_CDEF);

    // R10: reset again clears everything
    rst_n = 1'b0;
    #2;
    chk64("R10 re-reset elo0", elo0_q, 64'h0);
    chk64("R10 re-reset tag",  tag_q,  64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule